// File: doc/BRIEF.md
# Codec Serial Port Frame Controller

This block is the digital front end of the serial port on a two-channel voice codec. A DSP shifts 16-bit frames into it, MSB first, each frame marked by a frame-sync pulse on its first bit. The controller sorts each received frame into one of two kinds. A frame is either a write to a small control register file, or a sample for one of the two DAC channels. The operating mode held in control register A decides which. On each sample strobe it serialises the two ADC sample words back to the DSP on the output port.

The mode bits select program mode, normal data mode, mixed program/data mode, digital loop-back and serial-port loop-back. In mixed mode the frame MSB is a flag that separates control frames from data frames. The two loop-back modes stay latched until reset unless mixed mode is active when a clearing write arrives. An analog loop-back enable comes out of the register file, gated by an interlock on the analog gain-tap power bit. The converters themselves sit outside. They appear here as two parallel ADC words with a strobe, and two DAC output registers.

Top module: `codec_sport_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it rises, both DAC outputs are 0, `tx_fs` and `tx_bit` are 0, `alb_active` is 0, and register A is 0, which means program mode.
- R2: In program mode (register A bit 0 = 0) every frame is a control write, whatever its MSB: frame bits 10:8 give the register address and bits 7:0 give the data. The write takes effect one cycle after the frame's last bit is sampled. Writing register A with bits 1:0 = 11 enters mixed mode straight away.
- R3: In mixed mode (register A bits 1 and 0 both 1), a frame with bit 15 = 1 is a control write laid out as in R2. A frame with bit 15 = 0 is DAC data, and the DAC receives bits 14:0 shifted up by one with bit 0 = 0.
- R4: In normal data mode (register A bit 0 = 1, bit 1 = 0), every frame is a full 16-bit DAC word. Data words alternate between slot A and slot B. Both DACs load together when the slot B word arrives, and only when the device-count field, register A bits 6:4, equals 001. Its reset value 000 gives no DAC update.
- R5: `adc_strobe` returns the slot order to slot A. A data frame that completes in the same cycle as the strobe is first handled in the current slot, which commits the pair if it was slot B. The slot order is then reset.
- R6: When serial-port loop-back is off, an `adc_strobe` starts a 32-cycle transmission in the next cycle: `adc_a` then `adc_b`, MSB first. `tx_fs` is high on the first bit of each word.
- R7: In mixed mode, the transmitted ADC words have bit 15 forced to 0.
- R8: With digital loop-back set (register A bit 2), each `adc_strobe` loads `adc_a`/`adc_b` into `dac_a`/`dac_b`. Serial data frames leave the DACs unchanged, and control frames are still accepted.
- R9: With serial-port loop-back set (register A bit 3), `tx_fs` and `tx_bit` reproduce `rx_fs` and `rx_bit` exactly 16 cycles later, and no ADC words are sent.
- R10: A write to register A clears bits 2 and 3 only if mixed mode was active before that write. Otherwise those bits keep their set value.
- R11: `alb_active` is register F (address 5) bit 7 gated by register C (address 2) bit 1 being 0, and it changes only after a control frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fs | input | 1 | Receive frame sync, high with the first bit |
| rx_bit | input | 1 | Receive serial data, MSB first |
| tx_fs | output | 1 | Transmit frame sync |
| tx_bit | output | 1 | Transmit serial data |
| adc_strobe | input | 1 | New ADC sample pair; starts a sample period |
| adc_a | input | 16 | Channel A ADC word |
| adc_b | input | 16 | Channel B ADC word |
| dac_a | output | 16 | Channel A DAC register |
| dac_b | output | 16 | Channel B DAC register |
| alb_active | output | 1 | Effective analog loop-back enable |

## Verification
The collision of interest is a sample strobe that lands in the very cycle a received data frame is committed. The bench places `adc_strobe` one cycle after the last bit of a frame is sampled. It does this once on a slot B frame, where the pair must still load, and once on a slot A frame, where that word must be used and the order must then restart. Which pair reaches the DACs on the following frames shows whether the frame or the strobe was wrongly dropped. A second overlap comes from strobes issued while digital loop-back runs alongside serial data, and while serial loop-back is echoing frames.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;
   // register addresses
   localparam int unsigned RA = 0;
   localparam int unsigned RC = 2;
   localparam int unsigned RF = 5;
   // register A fields
   localparam int unsigned A_DP  = 0;
   localparam int unsigned A_MM  = 1;
   localparam int unsigned A_DLB = 2;
   localparam int unsigned A_SLB = 3;
   localparam int unsigned A_DC  = 4;
   localparam int unsigned DC_W  = 3;
   // register C / F fields
   localparam int unsigned C_TAP = 1;
   localparam int unsigned F_ALB = 7;

   typedef struct packed {
      logic prog;
      logic mixed;
      logic normal;
      logic dlb;
      logic slb;
      logic dc_two;
      logic alb;
   } mode_t;
endpackage

// File: rtl/codec_sp_rx.sv
module codec_sp_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fs,
   input  logic               din,
   output logic [FRAME_W-1:0] word,
   output logic               valid
);
   localparam int CNT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (fs) begin
            sh  <= {sh[FRAME_W-2:0], din};
            cnt <= CNT_W'(1);
         end else if (cnt != '0) begin
            sh <= {sh[FRAME_W-2:0], din};
            if (cnt == CNT_W'(FRAME_W-1)) begin
               cnt   <= '0;
               valid <= 1'b1;
               word  <= {sh[FRAME_W-2:0], din};
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/codec_sp_regs.sv
module codec_sp_regs
   import codec_sport_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [REG_W-1:0]  wdata,
   output mode_t             mode
);
   localparam int NREG = 1 << ADDR_W;
   localparam logic [NREG-1:0] IMPL =
      (NREG'(1) << RA) | (NREG'(1) << RC) | (NREG'(1) << RF);
   localparam logic [REG_W-1:0] HOLD_MASK =
      (REG_W'(1) << A_DLB) | (REG_W'(1) << A_SLB);

   logic [NREG-1:0][REG_W-1:0] rf;
   logic mixed_now;

   assign mixed_now = rf[RA][A_MM] & rf[RA][A_DP];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (IMPL[i]) begin : g_q
         logic [REG_W-1:0] q;
         logic [REG_W-1:0] keep;
         if (i == RA) begin : g_lock
            assign keep = mixed_now ? '0 : (q & HOLD_MASK);
         end else begin : g_free
            assign keep = '0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr && waddr == ADDR_W'(i))
               q <= wdata | keep;
         end
         assign rf[i] = q;
      end else begin : g_none
         assign rf[i] = '0;
      end
   end

   assign mode.prog   = ~rf[RA][A_DP];
   assign mode.mixed  = mixed_now;
   assign mode.normal = rf[RA][A_DP] & ~rf[RA][A_MM];
   assign mode.dlb    = rf[RA][A_DLB];
   assign mode.slb    = rf[RA][A_SLB];
   assign mode.dc_two = (rf[RA][A_DC +: DC_W] == DC_W'(1));
   assign mode.alb    = rf[RF][F_ALB] & ~rf[RC][C_TAP];
endmodule

// File: rtl/codec_sp_tx.sv
module codec_sp_tx #(
   parameter int FRAME_W  = 16,
   parameter int LB_DEPTH = 16,
   parameter bit ECHO_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] word_a,
   input  logic [FRAME_W-1:0] word_b,
   input  logic               echo,
   input  logic               rx_fs,
   input  logic               rx_bit,
   output logic               tx_fs,
   output logic               tx_bit
);
   localparam int SH_W  = 2 * FRAME_W;
   localparam int CNT_W = $clog2(SH_W);

   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             eng_fs, eng_bit;
   logic             echo_fs, echo_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= {word_a, word_b};
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         sh  <= {sh[SH_W-2:0], 1'b0};
         cnt <= cnt + CNT_W'(1);
         if (cnt == CNT_W'(SH_W-1))
            busy <= 1'b0;
      end
   end

   assign eng_fs  = busy & ((cnt == '0) | (cnt == CNT_W'(FRAME_W)));
   assign eng_bit = busy & sh[SH_W-1];

   if (ECHO_EN) begin : g_echo
      logic [LB_DEPTH-1:0] dfs, dbit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dfs  <= '0;
            dbit <= '0;
         end else begin
            dfs  <= {dfs[LB_DEPTH-2:0], rx_fs};
            dbit <= {dbit[LB_DEPTH-2:0], rx_bit};
         end
      end
      assign echo_fs  = dfs[LB_DEPTH-1];
      assign echo_bit = dbit[LB_DEPTH-1];
   end else begin : g_no_echo
      assign echo_fs  = 1'b0;
      assign echo_bit = 1'b0;
   end

   assign tx_fs  = echo ? echo_fs  : eng_fs;
   assign tx_bit = echo ? echo_bit : eng_bit;
endmodule

// File: rtl/codec_sport_ctrl.sv
module codec_sport_ctrl
   import codec_sport_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int ADDR_W  = 3,
   parameter int REG_W   = 8,
   parameter bit ECHO_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_fs,
   input  logic               rx_bit,
   output logic               tx_fs,
   output logic               tx_bit,
   input  logic               adc_strobe,
   input  logic [FRAME_W-1:0] adc_a,
   input  logic [FRAME_W-1:0] adc_b,
   output logic [FRAME_W-1:0] dac_a,
   output logic [FRAME_W-1:0] dac_b,
   output logic               alb_active
);
   localparam int MSB = FRAME_W - 1;

   if (FRAME_W < ADDR_W + REG_W + 1) begin : g_bad_frame
      $error("FRAME_W cannot hold flag, address and data");
   end
   if (REG_W < 8) begin : g_bad_reg
      $error("REG_W must cover field bit 7");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach address 5");
   end

   logic [FRAME_W-1:0] frm_word;
   logic               frm_valid;
   mode_t              mode;
   logic               is_ctrl, is_data, data_v, commit;
   logic [FRAME_W-1:0] dac_word, hold_a, tx_a, tx_b;
   logic               slot;

   codec_sp_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .fs(rx_fs), .din(rx_bit),
      .word(frm_word), .valid(frm_valid)
   );

   assign is_ctrl = mode.prog | (mode.mixed & frm_word[MSB]);
   assign is_data = mode.normal | (mode.mixed & ~frm_word[MSB]);

   codec_sp_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr(frm_valid & is_ctrl),
      .waddr(frm_word[REG_W +: ADDR_W]),
      .wdata(frm_word[REG_W-1:0]),
      .mode(mode)
   );

   assign dac_word = mode.mixed ? {frm_word[MSB-1:0], 1'b0} : frm_word;
   assign data_v   = frm_valid & is_data;
   assign commit   = data_v & slot & mode.dc_two & ~mode.dlb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_a <= '0;
         dac_a  <= '0;
         dac_b  <= '0;
         slot   <= 1'b0;
      end else begin
         if (data_v && !slot)
            hold_a <= dac_word;
         if (adc_strobe && mode.dlb) begin
            dac_a <= adc_a;
            dac_b <= adc_b;
         end else if (commit) begin
            dac_a <= hold_a;
            dac_b <= dac_word;
         end
         if (adc_strobe)
            slot <= 1'b0;
         else if (data_v)
            slot <= ~slot;
      end
   end

   assign tx_a = mode.mixed ? {1'b0, adc_a[MSB-1:0]} : adc_a;
   assign tx_b = mode.mixed ? {1'b0, adc_b[MSB-1:0]} : adc_b;

   codec_sp_tx #(.FRAME_W(FRAME_W), .LB_DEPTH(FRAME_W), .ECHO_EN(ECHO_EN)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(adc_strobe & ~mode.slb),
      .word_a(tx_a), .word_b(tx_b),
      .echo(mode.slb), .rx_fs(rx_fs), .rx_bit(rx_bit),
      .tx_fs(tx_fs), .tx_bit(tx_bit)
   );

   assign alb_active = mode.alb;
endmodule

// File: rtl/codec_sport_ctrl_chk.sv
module codec_sport_ctrl_chk #(
   parameter int FRAME_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               adc_strobe,
   input logic [FRAME_W-1:0] adc_a,
   input logic [FRAME_W-1:0] adc_b,
   input logic [FRAME_W-1:0] dac_a,
   input logic [FRAME_W-1:0] dac_b,
   input logic               tx_fs,
   input logic               tx_bit,
   input logic               alb_active,
   input logic               mixed_on,
   input logic               dlb_on,
   input logic               slb_on,
   input logic               dc_two,
   input logic               frm_valid
);
   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (dac_a == '0 && dac_b == '0 && !tx_fs && !alb_active));

   assert_pair_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dc_two && !dlb_on) |=> ($stable(dac_a) && $stable(dac_b)));

   assert_tx_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_strobe && !slb_on) |=> (tx_fs || slb_on));

   assert_tx_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_strobe && mixed_on && !slb_on) |=> (!tx_bit || slb_on));

   assert_dlb_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_strobe && dlb_on) |=> (dac_a == $past(adc_a) && dac_b == $past(adc_b)));

   assert_dlb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dlb_on && !mixed_on) |=> dlb_on);

   assert_slb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slb_on && !mixed_on) |=> slb_on);

   assert_alb_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> $stable(alb_active));
endmodule

bind codec_sport_ctrl codec_sport_ctrl_chk #(.FRAME_W(FRAME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_strobe(adc_strobe),
   .adc_a(adc_a), .adc_b(adc_b), .dac_a(dac_a), .dac_b(dac_b),
   .tx_fs(tx_fs), .tx_bit(tx_bit), .alb_active(alb_active),
   .mixed_on(mode.mixed), .dlb_on(mode.dlb), .slb_on(mode.slb),
   .dc_two(mode.dc_two), .frm_valid(frm_valid)
);

// File: tb/sim_codec_sport_ctrl.sv
module sim_codec_sport_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_fs = 1'b0, rx_bit = 1'b0;
   logic        tx_fs, tx_bit;
   logic        adc_strobe = 1'b0;
   logic [15:0] adc_a = '0, adc_b = '0;
   logic [15:0] dac_a, dac_b;
   logic        alb_active;
   int          checks = 0, fails = 0;

   always #2 clk = ~clk;

   codec_sport_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .rx_fs(rx_fs), .rx_bit(rx_bit),
      .tx_fs(tx_fs), .tx_bit(tx_bit), .adc_strobe(adc_strobe),
      .adc_a(adc_a), .adc_b(adc_b), .dac_a(dac_a), .dac_b(dac_b),
      .alb_active(alb_active)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rx_fs = 1'b0; rx_bit = 1'b0; adc_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // returns one negedge after the last bit
   task automatic send_frame(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk);
         rx_fs  = (i == 15);
         rx_bit = w[i];
      end
      @(negedge clk);
      rx_fs = 1'b0; rx_bit = 1'b0;
   endtask

   task automatic put(input logic [15:0] w);
      send_frame(w);
      @(negedge clk);
   endtask

   task automatic strobe(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      adc_a = a; adc_b = b; adc_strobe = 1'b1;
      @(negedge clk);
      adc_strobe = 1'b0;
   endtask

   task automatic tx_run(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] ea, input logic [15:0] eb);
      logic [31:0] gb, gf;
      strobe(a, b);
      for (int i = 0; i < 32; i++) begin
         if (i > 0) @(negedge clk);
         gb[31-i] = tx_bit;
         gf[31-i] = tx_fs;
      end
      chk({tag, " tx data"}, gb, {ea, eb});
      chk({tag, " tx frame sync"}, gf, 32'h8000_8000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] w1, w2;
      int          errs;
      logic        efs [64];
      logic        ebt [64];

      // ---------------- R1 reset state
      do_reset();
      chk("R1 dac_a", dac_a, 0);
      chk("R1 dac_b", dac_b, 0);
      chk("R1 tx idle", {tx_fs, tx_bit}, 0);
      chk("R1 alb", alb_active, 0);

      // ---------------- R6 transmit in program mode
      tx_run("R6", 16'hA5C3, 16'h8001, 16'hA5C3, 16'h8001);

      // ---------------- R2 / R11 program-mode writes and interlock
      put(16'h0202);                     // C: tap powered
      put(16'h0580);                     // F: loop-back request
      chk("R11 tap blocks alb", alb_active, 0);
      put(16'h0200);                     // C: tap off
      chk("R11 alb on", alb_active, 1);
      put(16'h0500);
      chk("R11 alb off", alb_active, 0);
      put(16'h8580);                     // MSB set still control in program mode
      chk("R2 msb ignored in program mode", alb_active, 1);

      // ---------------- R4 device count 000 gives no update
      do_reset();
      put(16'h0001);
      strobe(16'h0, 16'h0);
      put(16'h1234);
      put(16'h5678);
      chk("R4 count 000 no dac_a", dac_a, 0);
      chk("R4 count 000 no dac_b", dac_b, 0);

      // ---------------- R4 normal data mode sweep
      do_reset();
      put(16'h0011);
      strobe(16'h0, 16'h0);
      w1 = 16'h0; w2 = 16'h0;
      for (int k = 0; k < 6; k++) begin
         logic [15:0] pa, pb;
         pa = 16'(k * 16'h1357) ^ 16'hA0A0;
         pb = ~pa + 16'(k);
         put(pa);
         chk("R4 single word held", dac_a, w1);
         put(pb);
         chk("R4 pair dac_a", dac_a, pa);
         chk("R4 pair dac_b", dac_b, pb);
         w1 = pa; w2 = pb;
      end
      put(16'h8580);                     // data, not a control write
      put(16'h8581);
      chk("R4 control-like word is data", alb_active, 0);
      chk("R4 control-like word to dac_a", dac_a, 16'h8580);

      // ---------------- R5 strobe on the slot B frame
      strobe(16'h0, 16'h0);
      put(16'h1111);
      send_frame(16'h2222);
      adc_strobe = 1'b1;
      @(negedge clk);
      adc_strobe = 1'b0;
      chk("R5 commit with strobe dac_a", dac_a, 16'h1111);
      chk("R5 commit with strobe dac_b", dac_b, 16'h2222);
      repeat (34) @(negedge clk);
      // strobe on the slot A frame: word used, then order restarts
      send_frame(16'h3333);
      adc_strobe = 1'b1;
      @(negedge clk);
      adc_strobe = 1'b0;
      put(16'h4444);
      chk("R5 slot A restart holds", dac_a, 16'h1111);
      put(16'h5555);
      chk("R5 restart pair dac_a", dac_a, 16'h4444);
      chk("R5 restart pair dac_b", dac_b, 16'h5555);
      repeat (34) @(negedge clk);

      // ---------------- R3 / R7 mixed mode entered directly
      do_reset();
      put(16'h0013);
      strobe(16'h0, 16'h0);
      repeat (34) @(negedge clk);
      put(16'h1234);
      put(16'h0ABC);
      chk("R3 data justify dac_a", dac_a, 16'h2468);
      chk("R3 data justify dac_b", dac_b, 16'h1578);
      put(16'h8580);
      chk("R3 flagged control", alb_active, 1);
      tx_run("R7", 16'hFFFF, 16'h8421, 16'h7FFF, 16'h0421);

      // ---------------- R8 digital loop-back in mixed mode
      put(16'h8017);
      strobe(16'h1111, 16'h2222);
      chk("R8 copy dac_a", dac_a, 16'h1111);
      chk("R8 copy dac_b", dac_b, 16'h2222);
      repeat (34) @(negedge clk);
      put(16'h0001);
      put(16'h0002);
      chk("R8 serial data ignored", dac_a, 16'h1111);
      put(16'h8500);
      chk("R8 control still taken", alb_active, 0);
      put(16'h8013);                     // clear while mixed
      strobe(16'h3333, 16'h4444);
      chk("R10 cleared in mixed", dac_a, 16'h1111);
      repeat (34) @(negedge clk);

      // ---------------- R10 lock outside mixed mode
      do_reset();
      put(16'h0004);
      strobe(16'h0101, 16'h0202);
      chk("R8 copy in program mode", dac_b, 16'h0202);
      repeat (34) @(negedge clk);
      put(16'h0000);
      strobe(16'h0303, 16'h0404);
      chk("R10 locked bit survives", dac_a, 16'h0303);
      repeat (34) @(negedge clk);
      put(16'h0013);
      put(16'h8013);
      strobe(16'h0505, 16'h0606);
      chk("R10 clear after mixed", dac_a, 16'h0303);
      repeat (34) @(negedge clk);

      // ---------------- R9 serial loop-back echo
      do_reset();
      put(16'h0008);
      repeat (20) @(negedge clk);
      errs = 0;
      for (int n = 0; n < 60; n++) begin
         logic f, b;
         @(negedge clk);
         if (n >= 16) begin
            if (tx_fs !== efs[n-16] || tx_bit !== ebt[n-16]) errs++;
         end
         f = 1'b0; b = 1'b0;
         if (n >= 2 && n <= 17) begin
            f = (n == 2); b = 16'hC3A5 >> (17 - n);
         end else if (n >= 18 && n <= 33) begin
            f = (n == 18); b = 16'h0F0F >> (33 - n);
         end
         rx_fs = f; rx_bit = b;
         efs[n] = f; ebt[n] = b;
         adc_strobe = (n == 20);
         adc_a = 16'hFFFF; adc_b = 16'hFFFF;
      end
      rx_fs = 1'b0; rx_bit = 1'b0; adc_strobe = 1'b0;
      chk("R9 echo mismatches", errs, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule